// File: doc/BRIEF.md
# Saturating Arithmetic Execution Unit

This unit sits beside the integer pipeline of a 32-bit processor and executes a group of custom register-register instructions. It receives the raw instruction word and both register operands. It decodes the word, evaluates one of seven operations and returns the result one clock later.

The seven operations are:
- signed and unsigned add, each clamped to its range;
- signed and unsigned subtract, each clamped to its range;
- a left shift clamped to the signed range;
- a left shift clamped to the unsigned range;
- a wraparound step that either subtracts, adds or passes the first operand through.

Both shifts work on a double-width copy of the operand, so the clamp decision sees every bit that the shift moves out.

A word that is not one of the seven encodings is rejected: the valid output stays low and the data output is zero. The register file, hazard control and writeback stay with the surrounding pipeline.

Top module: `satalu_unit`

## Requirements
- R1: A word is accepted only when bits [6:0] are 0001011, bits [14:12] are 011 and bits [31:25] hold one of these codes: 0001110 signed add, 0001111 unsigned add, 0010000 signed subtract, 0010001 unsigned subtract, 0001010 signed-clamped shift, 0001100 unsigned-clamped shift, 0010010 wraparound. Bits [24:15] and [11:7] have no effect. Any other word gives out_valid low and out_data zero.
- R2: Signed add returns a+b. When both operands share a sign and the sum's sign differs from it, the result is 0x80000000 if a is negative and 0x7FFFFFFF otherwise.
- R3: Unsigned add returns a+b, or 0xFFFFFFFF when the addition carries out of bit 31.
- R4: Signed subtract returns a-b. When the operands differ in sign and the difference's sign differs from a's, the result is 0x80000000 if a is negative and 0x7FFFFFFF otherwise.
- R5: Unsigned subtract returns 0 when a < b unsigned, and a-b otherwise.
- R6: The signed-clamped shift sign-extends a to 64 bits and shifts it left by b[4:0]; the higher bits of b have no effect. The 64-bit value is then clamped to the signed range 0x80000000..0x7FFFFFFF.
- R7: The unsigned-clamped shift sign-extends a to 64 bits and shifts it left by b[4:0]. If the 64-bit value is above 0xFFFFFFFF unsigned, the result is 0xFFFFFFFF; otherwise it is the low 32 bits.
- R8: Wraparound returns a-b when a >= b signed. Otherwise it returns a+b (modulo 2^32) if a is negative, and a unchanged if it is not.
- R9: Outputs are registered with one cycle of latency, and a synchronous active-high reset clears them. With in_valid low, the next cycle shows out_valid 0 and out_data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word and operands are present |
| in_instr | input | 32 | Raw instruction word |
| in_a | input | XLEN | First register operand |
| in_b | input | XLEN | Second register operand (shift amount in low bits) |
| out_valid | output | 1 | Registered: previous word was valid and decoded |
| out_data | output | XLEN | Registered result, zero when out_valid is low |

## Verification
The assertions check several rules on every cycle:
- an idle or rejected cycle yields zero data;
- unsigned add pins to all ones on carry, and unsigned subtract floors at zero on borrow;
- signed add keeps the shared operand sign;
- both shifts clamp correctly for negative operands;
- wraparound passes through a non-negative first operand that is below the second.

Only the bench's sweeps can show that the exact values are right. These sweeps cover boundary operands crossed with every operation, random operands, ignored register fields, upper shift-amount bits and neighbouring illegal encodings. The sweeps compare against a 64-bit arithmetic model.

// File: rtl/satalu_pkg.sv
package satalu_pkg;
  localparam logic [6:0] MAJOR_OPC = 7'b0001011;
  localparam logic [2:0] GROUP_F3  = 3'b011;

  localparam logic [6:0] F7_SADD = 7'b0001110;
  localparam logic [6:0] F7_UADD = 7'b0001111;
  localparam logic [6:0] F7_SSUB = 7'b0010000;
  localparam logic [6:0] F7_USUB = 7'b0010001;
  localparam logic [6:0] F7_SLA  = 7'b0001010;
  localparam logic [6:0] F7_SLL  = 7'b0001100;
  localparam logic [6:0] F7_WRAP = 7'b0010010;

  typedef enum logic [2:0] {
    OP_NONE, OP_SADD, OP_UADD, OP_SSUB, OP_USUB, OP_SLA, OP_SLL, OP_WRAP
  } satalu_op_e;
endpackage

// File: rtl/satalu_decode.sv
module satalu_decode
  import satalu_pkg::*;
(
  input  logic [6:0] funct7,
  input  logic [2:0] funct3,
  input  logic [6:0] opcode,
  output satalu_op_e op,
  output logic       hit
);
  logic group_ok;
  assign group_ok = (opcode == MAJOR_OPC) && (funct3 == GROUP_F3);

  always_comb begin
    op = OP_NONE;
    if (group_ok) begin
      unique case (funct7)
        F7_SADD: op = OP_SADD;
        F7_UADD: op = OP_UADD;
        F7_SSUB: op = OP_SSUB;
        F7_USUB: op = OP_USUB;
        F7_SLA:  op = OP_SLA;
        F7_SLL:  op = OP_SLL;
        F7_WRAP: op = OP_WRAP;
        default: op = OP_NONE;
      endcase
    end
  end

  assign hit = (op != OP_NONE);
endmodule

// File: rtl/satalu_addsub.sv
module satalu_addsub #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] sadd_res,
  output logic [XLEN-1:0] uadd_res,
  output logic [XLEN-1:0] ssub_res,
  output logic [XLEN-1:0] usub_res,
  output logic [XLEN-1:0] wrap_res
);
  localparam int MSB = XLEN - 1;
  localparam logic [XLEN-1:0] SMAX = {1'b0, {(XLEN-1){1'b1}}};
  localparam logic [XLEN-1:0] SMIN = {1'b1, {(XLEN-1){1'b0}}};

  logic [XLEN:0] sum_ext;
  logic [XLEN:0] dif_ext;
  logic          add_ovf, sub_ovf, signed_lt, borrow, carry;
  logic [XLEN-1:0] clamp_val;

  assign sum_ext = {1'b0, a} + {1'b0, b};
  assign dif_ext = {1'b0, a} - {1'b0, b};
  assign carry   = sum_ext[XLEN];
  assign borrow  = dif_ext[XLEN];

  // Overflow flags from operand and result sign bits
  assign add_ovf = (a[MSB] == b[MSB]) && (sum_ext[MSB] != a[MSB]);
  assign sub_ovf = (a[MSB] != b[MSB]) && (dif_ext[MSB] != a[MSB]);
  // Signed less-than reuses the subtractor: negative xor overflow
  assign signed_lt = dif_ext[MSB] ^ sub_ovf;
  assign clamp_val = a[MSB] ? SMIN : SMAX;

  assign sadd_res = add_ovf ? clamp_val : sum_ext[XLEN-1:0];
  assign uadd_res = carry ? {XLEN{1'b1}} : sum_ext[XLEN-1:0];
  assign ssub_res = sub_ovf ? clamp_val : dif_ext[XLEN-1:0];
  assign usub_res = borrow ? '0 : dif_ext[XLEN-1:0];

  always_comb begin
    if (!signed_lt)   wrap_res = dif_ext[XLEN-1:0];
    else if (a[MSB])  wrap_res = sum_ext[XLEN-1:0];
    else              wrap_res = a;
  end
endmodule

// File: rtl/satalu_shift.sv
module satalu_shift #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]         a,
  input  logic [$clog2(XLEN)-1:0] shamt,
  output logic [XLEN-1:0]         sla_res,
  output logic [XLEN-1:0]         sll_res
);
  localparam int WIDE = 2 * XLEN;
  localparam logic [XLEN-1:0] SMAX = {1'b0, {(XLEN-1){1'b1}}};
  localparam logic [XLEN-1:0] SMIN = {1'b1, {(XLEN-1){1'b0}}};

  logic [WIDE-1:0] ext, shifted;
  logic [XLEN:0]   upper_s;     // bits that must all equal the sign to fit signed
  logic            fits_signed, fits_unsigned;

  assign ext     = {{XLEN{a[XLEN-1]}}, a};
  assign shifted = ext << shamt;
  assign upper_s = shifted[WIDE-1:XLEN-1];

  assign fits_signed   = (upper_s == '0) || (upper_s == '1);
  assign fits_unsigned = (shifted[WIDE-1:XLEN] == '0);

  assign sla_res = fits_signed ? shifted[XLEN-1:0] : (shifted[WIDE-1] ? SMIN : SMAX);
  assign sll_res = fits_unsigned ? shifted[XLEN-1:0] : {XLEN{1'b1}};
endmodule

// File: rtl/satalu_unit.sv
module satalu_unit
  import satalu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [31:0]     in_instr,
  input  logic [XLEN-1:0] in_a,
  input  logic [XLEN-1:0] in_b,
  output logic            out_valid,
  output logic [XLEN-1:0] out_data
);
  localparam int SHW = $clog2(XLEN);

  satalu_op_e      dec_op;
  logic            dec_hit;
  logic [XLEN-1:0] r_sadd, r_uadd, r_ssub, r_usub, r_wrap, r_sla, r_sll;
  logic [XLEN-1:0] sel_res;
  logic            take;

  satalu_decode u_dec (
    .funct7 (in_instr[31:25]),
    .funct3 (in_instr[14:12]),
    .opcode (in_instr[6:0]),
    .op     (dec_op),
    .hit    (dec_hit)
  );

  satalu_addsub #(.XLEN(XLEN)) u_as (
    .a(in_a), .b(in_b),
    .sadd_res(r_sadd), .uadd_res(r_uadd),
    .ssub_res(r_ssub), .usub_res(r_usub),
    .wrap_res(r_wrap)
  );

  satalu_shift #(.XLEN(XLEN)) u_sh (
    .a(in_a), .shamt(in_b[SHW-1:0]),
    .sla_res(r_sla), .sll_res(r_sll)
  );

  always_comb begin
    unique case (dec_op)
      OP_SADD: sel_res = r_sadd;
      OP_UADD: sel_res = r_uadd;
      OP_SSUB: sel_res = r_ssub;
      OP_USUB: sel_res = r_usub;
      OP_SLA:  sel_res = r_sla;
      OP_SLL:  sel_res = r_sll;
      OP_WRAP: sel_res = r_wrap;
      default: sel_res = '0;
    endcase
  end

  assign take = in_valid && dec_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= take;
      out_data  <= take ? sel_res : '0;
    end
  end

  // Idle or rejected cycles carry zero data (R1, R9)
  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> out_data == '0);

  // Carry out pins the unsigned sum to all ones
  assert_uadd_clamp_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(dec_op == OP_UADD) &&
     $past(({1'b0, in_a} + {1'b0, in_b}) > {1'b0, {XLEN{1'b1}}})) |-> out_data == '1);

  // Borrow floors the unsigned difference at zero
  assert_usub_floor_R5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(dec_op == OP_USUB) && $past(in_a < in_b)) |-> out_data == '0);

  // Same-sign operands never produce a result of the other sign
  assert_sadd_sign_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(dec_op == OP_SADD) && $past(in_a[XLEN-1] == in_b[XLEN-1]))
      |-> out_data[XLEN-1] == $past(in_a[XLEN-1]));

  // Negative operand: signed-clamped shift stays negative
  assert_sla_neg_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(dec_op == OP_SLA) && $past(in_a[XLEN-1])) |-> out_data[XLEN-1]);

  // Negative operand: unsigned-clamped shift saturates
  assert_sll_neg_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(dec_op == OP_SLL) && $past(in_a[XLEN-1])) |-> out_data == '1);

  // Non-negative a below b passes through unchanged
  assert_wrap_pass_R8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(dec_op == OP_WRAP) && $past(!in_a[XLEN-1]) &&
     $past($signed(in_a) < $signed(in_b))) |-> out_data == $past(in_a));
endmodule

// File: tb/satalu_unit_tb.sv
module satalu_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_instr = '0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        out_valid;
  logic [31:0] out_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  satalu_unit #(.XLEN(32)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_instr(in_instr),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_data(out_data)
  );

  // Operation codes indexed 0..6, with their requirement tags
  function automatic logic [6:0] f7_of(input int k);
    case (k)
      0: return 7'b0001110;
      1: return 7'b0001111;
      2: return 7'b0010000;
      3: return 7'b0010001;
      4: return 7'b0001010;
      5: return 7'b0001100;
      default: return 7'b0010010;
    endcase
  endfunction

  function automatic string tag_of(input int k);
    case (k)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [31:0] mk_instr(input logic [6:0] f7, input logic [2:0] f3,
                                           input logic [6:0] opc);
    logic [17:0] regs;
    regs = 18'($urandom);
    return {f7, regs[17:8], f3, regs[4:0], opc};
  endfunction

  function automatic longint clamp_s(input longint v);
    if (v > 64'sd2147483647)  return 64'sd2147483647;
    if (v < -64'sd2147483648) return -64'sd2147483648;
    return v;
  endfunction

  function automatic logic [31:0] model(input int k, input logic [31:0] a, input logic [31:0] b);
    longint sa, sb, ua, ub, r;
    logic [63:0] u;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ua = longint'({32'b0, a});
    ub = longint'({32'b0, b});
    case (k)
      0: r = clamp_s(sa + sb);
      1: r = (ua + ub > 64'sd4294967295) ? 64'sd4294967295 : ua + ub;
      2: r = clamp_s(sa - sb);
      3: r = (ua < ub) ? 0 : ua - ub;
      4: r = clamp_s(sa <<< b[4:0]);
      5: begin
        u = 64'(sa) << b[4:0];
        r = (u > 64'hFFFF_FFFF) ? 64'sd4294967295 : longint'(u);
      end
      default: r = (sa >= sb) ? sa - sb : ((sa < 0) ? sa + sb : sa);
    endcase
    return r[31:0];
  endfunction

  task automatic run(input logic v, input logic [31:0] ins, input logic [31:0] a,
                     input logic [31:0] b, input logic ev, input logic [31:0] ed,
                     input string tag);
    in_valid = v; in_instr = ins; in_a = a; in_b = b;
    @(negedge clk);
    n_checks++;
    if (out_valid !== ev || out_data !== ed) begin
      n_fail++;
      $display("FAIL %s instr=%h a=%h b=%h: got valid=%b data=%h, expected valid=%b data=%h",
               tag, ins, a, b, out_valid, out_data, ev, ed);
    end
  endtask

  task automatic run_op(input int k, input logic [31:0] a, input logic [31:0] b);
    run(1'b1, mk_instr(f7_of(k), 3'b011, 7'b0001011), a, b, 1'b1, model(k, a, b), tag_of(k));
  endtask

  logic [31:0] edge_v [10] = '{32'h0, 32'h1, 32'h2, 32'h7FFF_FFFF, 32'h8000_0000,
                               32'hFFFF_FFFF, 32'h4000_0000, 32'hC000_0000,
                               32'h0000_001F, 32'hFFFF_FFE1};

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] a, b;
    repeat (3) @(negedge clk);
    // R9: reset state
    n_checks++;
    if (out_valid !== 1'b0 || out_data !== 32'h0) begin
      n_fail++;
      $display("FAIL R9 reset: got valid=%b data=%h, expected 0/0", out_valid, out_data);
    end
    rst = 1'b0;

    // Boundary operands crossed with every operation
    for (int k = 0; k < 7; k++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 10; j++)
          run_op(k, edge_v[i], edge_v[j]);

    // Random operands
    for (int n = 0; n < 1500; n++)
      for (int k = 0; k < 7; k++)
        run_op(k, $urandom, $urandom);

    // R6 / R7: upper bits of b do not change the shift amount
    for (int s = 0; s < 32; s++) begin
      a = 32'h0000_0003;
      b = {27'($urandom) | 27'h1, 5'(s)};
      run(1'b1, mk_instr(f7_of(4), 3'b011, 7'b0001011), a, b, 1'b1, model(4, a, {27'b0, 5'(s)}), "R6");
      run(1'b1, mk_instr(f7_of(5), 3'b011, 7'b0001011), a, b, 1'b1, model(5, a, {27'b0, 5'(s)}), "R7");
    end

    // R1: every other funct7, plus wrong funct3 and wrong opcode
    for (int f = 0; f < 128; f++) begin
      bit legal;
      legal = 1'b0;
      for (int k = 0; k < 7; k++) if (7'(f) == f7_of(k)) legal = 1'b1;
      if (!legal)
        run(1'b1, mk_instr(7'(f), 3'b011, 7'b0001011), 32'h7FFF_FFFF, 32'h1, 1'b0, 32'h0, "R1");
    end
    for (int k = 0; k < 7; k++) begin
      run(1'b1, mk_instr(f7_of(k), 3'b010, 7'b0001011), 32'h5, 32'h3, 1'b0, 32'h0, "R1");
      run(1'b1, mk_instr(f7_of(k), 3'b011, 7'b0101011), 32'h5, 32'h3, 1'b0, 32'h0, "R1");
    end

    // R9: valid low suppresses a legal word
    run(1'b0, mk_instr(f7_of(1), 3'b011, 7'b0001011), 32'hFFFF_FFFF, 32'h1, 1'b0, 32'h0, "R9");
    run(1'b1, mk_instr(f7_of(1), 3'b011, 7'b0001011), 32'hFFFF_FFFF, 32'h1, 1'b1, 32'hFFFF_FFFF, "R3");
    run(1'b0, 32'h0, 32'h0, 32'h0, 1'b0, 32'h0, "R9");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule